// File: doc/BRIEF.md
# Symmetric Optimal Pulse Pattern Sequencer

This block plays back a precomputed multilevel switching pattern for one phase leg of a five-level converter built from series half-bridge submodules. Only the first quarter of the fundamental period is stored. The table holds up to `MAX_ANG` switching angles, and each angle has a direction flag that steps the output one level up or one level down. A 16-bit phase input gives the position inside the fundamental period as an unsigned fraction. The block folds the phase into the stored quarter using quarter-wave and half-wave symmetry, and works out the output level. It then splits that level into complementary insertion counts for the upper and lower arms. Because the pattern is tied to the phase, every period contains the same fixed number of switchings.

Software fills a staging copy of the table through a simple write port. It then arms a swap. The staged pattern becomes live only when the phase wraps from the last quarter back to the first one, so a period is never played with half of one pattern and half of another. The staging copy is checked all the time against a minimum spacing between switching instants, and a fault flag reports any violation before the pattern is committed.

Top module: `pulse_pattern_player`

## Requirements
- R1: After reset the level output is 0, both arm counts are 2, the spacing fault is 0, and the live table is empty, so the level is 0 at every phase until a pattern is committed.
- R2: For a phase p in the first quarter (p[15:14] = 0), the level is the sum of the steps of all live entries whose angle is less than or equal to p. An entry with `wrUp` = 1 steps by +1, and an entry with `wrUp` = 0 steps by -1. Angles use the same 16-bit full-period units as the phase.
- R3: For p in the second quarter (p[15:14] = 1), the level equals the first-quarter rule evaluated at 0x8000 - p. This mirrors each angle a to π - a.
- R4: For p in the second half (p[15] = 1), the level is the negation of the first-half rule evaluated at p - 0x8000.
- R5: The outputs are registered. One clock after a phase is presented, `level` holds the signed level L and the arm counts are `lowerCnt` = 2 + L and `upperCnt` = 2 - L, which always add up to 4.
- R6: Writes to entries and to the entry count change only the staging copy. After `armReq`, the staging copy becomes live at the first clock where the previous phase was in quarter 3 and the present phase is in quarter 0. Until then the output still follows the old pattern.
- R7: A running sum outside the range -2..+2 saturates to the nearest end of that range before the half-wave negation is applied.
- R8: `gapFault` is valid one clock after a staging write. It is 1 when, among the staged entries below the staged count, the first angle doubled is less than `MIN_GAP`, or consecutive angles differ by less than `MIN_GAP`, or twice the distance from the last angle to 0x4000 is less than `MIN_GAP`. With a count of 0 it is 0.
- R9: Entries at an index at or above the live count have no effect on the level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phase | input | 16 | Position in the fundamental period, unsigned fraction of a full period |
| armReq | input | 1 | Request to make the staging pattern live at the next phase wrap |
| wrEn | input | 1 | Write strobe for one staging entry |
| wrAddr | input | 3 | Staging entry index |
| wrAngle | input | 16 | Switching angle of the entry |
| wrUp | input | 1 | Step direction of the entry: 1 up, 0 down |
| cntWrEn | input | 1 | Write strobe for the staging entry count |
| cntData | input | 4 | Number of valid staging entries |
| level | output | 4 | Signed output level, -2..+2 |
| upperCnt | output | 3 | Submodules inserted in the upper arm |
| lowerCnt | output | 3 | Submodules inserted in the lower arm |
| gapFault | output | 1 | Staging pattern breaks the minimum switching spacing |

## Verification
The bench sweeps the phase across all four quarters and also probes exact angle edges. A fold that is wrong by one quadrant, or that misses the mirror or the sign flip, then shows up as an asymmetric or unsigned waveform. It writes a new pattern and arms it, then moves the phase inside the period without a wrap. A design that swapped tables too early would change level in the middle of the period. It stacks three upward steps to push the sum past the top level, so a missing clamp would give a count of 5 or more in one arm. It places near-boundary and tightly spaced angles, as well as a stale entry beyond the count, so a spacing check that ignored the boundary mirrors would leave `gapFault` clear, and a sum that ignored the count would take in the stale step.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;
  // strobes the control half hands to the datapath half
  typedef struct packed {
    logic commit;   // copy staging table into the live table this edge
  } seqStrobes_t;
endpackage

// File: rtl/pps_ctrl.sv
`timescale 1ns/1ps
module pps_ctrl
  import pps_pkg::*;
#(
  parameter int PW      = 16,
  parameter int MAX_ANG = 8,
  parameter int MIN_GAP = 33
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   quadrant,
  input  logic                         armReq,
  input  logic                         wrEn,
  input  logic [$clog2(MAX_ANG)-1:0]   wrAddr,
  input  logic [PW-1:0]                wrAngle,
  input  logic                         wrUp,
  input  logic                         cntWrEn,
  input  logic [$clog2(MAX_ANG+1)-1:0] cntData,
  output seqStrobes_t                  strobes,
  output logic [PW-1:0]                stageAngle [MAX_ANG],
  output logic [MAX_ANG-1:0]           stageUp,
  output logic [$clog2(MAX_ANG+1)-1:0] stageCount,
  output logic                         gapFault
);
  localparam int QUARTER = 1 << (PW - 2);

  logic       pending;
  logic [1:0] prevQuad;
  logic       wrapSeen;
  logic       gapBad;

  // staging table, written by software
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_ANG; i++) stageAngle[i] <= '0;
      stageUp    <= '0;
      stageCount <= '0;
    end else begin
      if (wrEn && (int'(wrAddr) < MAX_ANG)) begin
        stageAngle[wrAddr] <= wrAngle;
        stageUp[wrAddr]    <= wrUp;
      end
      if (cntWrEn) stageCount <= cntData;
    end
  end

  // swap request held until the phase wraps into quarter 0
  assign wrapSeen       = (prevQuad == 2'd3) && (quadrant == 2'd0);
  assign strobes.commit = pending && wrapSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      prevQuad <= 2'd0;
    end else begin
      pending  <= (pending && !strobes.commit) || armReq;
      prevQuad <= quadrant;
    end
  end

  // spacing check on the staging table, including the mirrored boundaries
  always_comb begin
    gapBad = 1'b0;
    if (stageCount != '0) begin
      if (2 * int'(stageAngle[0]) < MIN_GAP) gapBad = 1'b1;
    end
    for (int i = 1; i < MAX_ANG; i++) begin
      if (i < int'(stageCount)) begin
        if (int'(stageAngle[i]) - int'(stageAngle[i-1]) < MIN_GAP) gapBad = 1'b1;
      end
    end
    for (int i = 0; i < MAX_ANG; i++) begin
      if (i == int'(stageCount) - 1) begin
        if (2 * (QUARTER - int'(stageAngle[i])) < MIN_GAP) gapBad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gapFault <= 1'b0;
    else       gapFault <= gapBad;
  end

  // R6
  commit_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> ($past(quadrant) == 2'd3) && (quadrant == 2'd0));

  // R6
  pending_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit && !armReq |=> !pending);

  // R8
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && !cntWrEn |=> ##1 $stable(gapFault));
endmodule

// File: rtl/pps_datapath.sv
`timescale 1ns/1ps
module pps_datapath
  import pps_pkg::*;
#(
  parameter int PW      = 16,
  parameter int MAX_ANG = 8,
  parameter int ARM_SM  = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [PW-1:0]                        phase,
  input  seqStrobes_t                          strobes,
  input  logic [PW-1:0]                        stageAngle [MAX_ANG],
  input  logic [MAX_ANG-1:0]                   stageUp,
  input  logic [$clog2(MAX_ANG+1)-1:0]         stageCount,
  output logic signed [$clog2(ARM_SM+1):0]     levelOut,
  output logic [$clog2(ARM_SM+1)-1:0]          upperCnt,
  output logic [$clog2(ARM_SM+1)-1:0]          lowerCnt
);
  localparam int CNT_W   = $clog2(MAX_ANG + 1);
  localparam int SMC_W   = $clog2(ARM_SM + 1);
  localparam int LVL_W   = SMC_W + 1;
  localparam int HALF_SM = ARM_SM / 2;
  localparam int SUM_W   = CNT_W + 2;
  localparam logic [PW:0] HALF_PERIOD = {2'b01, {(PW-1){1'b0}}};
  localparam logic [PW:0] FULL_PERIOD = {1'b1, {PW{1'b0}}};
  localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'(HALF_SM);
  localparam logic signed [SUM_W-1:0] NEG_LIM = -SUM_W'(HALF_SM);

  logic [PW-1:0]              activeAngle [MAX_ANG];
  logic [MAX_ANG-1:0]         activeUp;
  logic [CNT_W-1:0]           activeCount;
  logic [1:0]                 quad;
  logic [PW:0]                foldX;
  logic signed [1:0]          stepVal [MAX_ANG];
  logic signed [SUM_W-1:0]    rawSum;
  logic signed [LVL_W-1:0]    clampedLvl;
  logic signed [LVL_W-1:0]    signedLvl;

  // live table, replaced whole at a commit strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_ANG; i++) activeAngle[i] <= '0;
      activeUp    <= '0;
      activeCount <= '0;
    end else if (strobes.commit) begin
      for (int i = 0; i < MAX_ANG; i++) activeAngle[i] <= stageAngle[i];
      activeUp    <= stageUp;
      activeCount <= stageCount;
    end
  end

  // fold any phase into the stored quarter
  assign quad = phase[PW-1 -: 2];
  always_comb begin
    case (quad)
      2'd0:    foldX = {1'b0, phase};
      2'd1:    foldX = HALF_PERIOD - {1'b0, phase};
      2'd2:    foldX = {1'b0, phase} - HALF_PERIOD;
      default: foldX = FULL_PERIOD - {1'b0, phase};
    endcase
  end

  // per-entry step contribution
  for (genvar gi = 0; gi < MAX_ANG; gi++) begin : g_step
    assign stepVal[gi] = ((CNT_W'(gi) < activeCount) && ({1'b0, activeAngle[gi]} <= foldX))
                         ? (activeUp[gi] ? 2'sd1 : -2'sd1) : 2'sd0;
  end

  always_comb begin
    rawSum = '0;
    for (int i = 0; i < MAX_ANG; i++)
      rawSum = rawSum + $signed({{(SUM_W-2){stepVal[i][1]}}, stepVal[i]});
  end

  always_comb begin
    if (rawSum > POS_LIM)      clampedLvl = LVL_W'(HALF_SM);
    else if (rawSum < NEG_LIM) clampedLvl = -LVL_W'(HALF_SM);
    else                       clampedLvl = LVL_W'(rawSum);
  end

  assign signedLvl = quad[1] ? -clampedLvl : clampedLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelOut <= '0;
      upperCnt <= SMC_W'(HALF_SM);
      lowerCnt <= SMC_W'(HALF_SM);
    end else begin
      levelOut <= signedLvl;
      upperCnt <= SMC_W'(HALF_SM) - SMC_W'(signedLvl);
      lowerCnt <= SMC_W'(HALF_SM) + SMC_W'(signedLvl);
    end
  end

  // R6
  table_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(activeCount) && $stable(activeUp));

  // R5
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $stable(phase) && !$past(strobes.commit) |=> $stable(levelOut));
endmodule

// File: rtl/pulse_pattern_player.sv
`timescale 1ns/1ps
module pulse_pattern_player
  import pps_pkg::*;
#(
  parameter int PW      = 16,
  parameter int MAX_ANG = 8,
  parameter int ARM_SM  = 4,
  parameter int MIN_GAP = 33
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [PW-1:0]                        phase,
  input  logic                                 armReq,
  input  logic                                 wrEn,
  input  logic [$clog2(MAX_ANG)-1:0]           wrAddr,
  input  logic [PW-1:0]                        wrAngle,
  input  logic                                 wrUp,
  input  logic                                 cntWrEn,
  input  logic [$clog2(MAX_ANG+1)-1:0]         cntData,
  output logic signed [$clog2(ARM_SM+1):0]     level,
  output logic [$clog2(ARM_SM+1)-1:0]          upperCnt,
  output logic [$clog2(ARM_SM+1)-1:0]          lowerCnt,
  output logic                                 gapFault
);
  localparam int CNT_W = $clog2(MAX_ANG + 1);

  seqStrobes_t        strobes;
  logic [PW-1:0]      stageAngle [MAX_ANG];
  logic [MAX_ANG-1:0] stageUp;
  logic [CNT_W-1:0]   stageCount;

  pps_ctrl #(.PW(PW), .MAX_ANG(MAX_ANG), .MIN_GAP(MIN_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .quadrant(phase[PW-1 -: 2]), .armReq(armReq),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrAngle(wrAngle), .wrUp(wrUp),
    .cntWrEn(cntWrEn), .cntData(cntData), .strobes(strobes),
    .stageAngle(stageAngle), .stageUp(stageUp), .stageCount(stageCount),
    .gapFault(gapFault)
  );

  pps_datapath #(.PW(PW), .MAX_ANG(MAX_ANG), .ARM_SM(ARM_SM)) u_dp (
    .clk(clk), .rstN(rstN), .phase(phase), .strobes(strobes),
    .stageAngle(stageAngle), .stageUp(stageUp), .stageCount(stageCount),
    .levelOut(level), .upperCnt(upperCnt), .lowerCnt(lowerCnt)
  );
endmodule

// File: tb/test_pulse_pattern_player.sv
`timescale 1ns/1ps
module test_pulse_pattern_player;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] phase = '0;
  logic        armReq = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrAngle = '0;
  logic        wrUp = 1'b0;
  logic        cntWrEn = 1'b0;
  logic [3:0]  cntData = '0;
  logic signed [3:0] level;
  logic [2:0]  upperCnt, lowerCnt;
  logic        gapFault;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // staging and live models built from the requirements
  int stAng [8];
  bit stUp  [8];
  int stCnt = 0;
  int lvAng [8];
  bit lvUp  [8];
  int lvCnt = 0;

  always #4 clk = ~clk;

  pulse_pattern_player i_pulse_pattern_player (
    .clk(clk), .rstN(rstN), .phase(phase), .armReq(armReq), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrAngle(wrAngle), .wrUp(wrUp), .cntWrEn(cntWrEn),
    .cntData(cntData), .level(level), .upperCnt(upperCnt),
    .lowerCnt(lowerCnt), .gapFault(gapFault)
  );

  function automatic int refLevel(int p);
    int q = p >> 14;
    int x;
    int s = 0;
    case (q)
      0: x = p;
      1: x = 32768 - p;
      2: x = p - 32768;
      default: x = 65536 - p;
    endcase
    for (int i = 0; i < lvCnt; i++)
      if (lvAng[i] <= x) s += lvUp[i] ? 1 : -1;
    if (s > 2) s = 2;
    if (s < -2) s = -2;
    return (q >= 2) ? -s : s;
  endfunction

  task automatic checkPhase(int p, string tag);
    int exp;
    @(negedge clk) phase = 16'(p);
    @(posedge clk); #1;
    exp = refLevel(p);
    checks++;
    if (int'(level) != exp || int'(upperCnt) != 2 - exp || int'(lowerCnt) != 2 + exp) begin
      fails++;
      $display("FAIL %s R5 phase=%h level/upper/lower act=%0d/%0d/%0d exp=%0d/%0d/%0d",
               tag, p[15:0], level, upperCnt, lowerCnt, exp, 2 - exp, 2 + exp);
    end
  endtask

  task automatic sweep(string tag);
    for (int k = 0; k < 64; k++) begin
      int p = k * 1024 + 37;
      string t = (p < 16384) ? "R2" : (p < 32768) ? "R3" : "R4";
      checkPhase(p, {tag, " ", t});
    end
  endtask

  task automatic writeEntry(int idx, int ang, bit up);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(idx); wrAngle = 16'(ang); wrUp = up;
    @(negedge clk) wrEn = 1'b0;
    stAng[idx] = ang; stUp[idx] = up;
  endtask

  task automatic writeCount(int n);
    @(negedge clk);
    cntWrEn = 1'b1; cntData = 4'(n);
    @(negedge clk) cntWrEn = 1'b0;
    stCnt = n;
  endtask

  task automatic armOnly();
    @(negedge clk) armReq = 1'b1;
    @(negedge clk) armReq = 1'b0;
  endtask

  task automatic wrapPhase();
    @(negedge clk) phase = 16'hF000;
    @(negedge clk) phase = 16'h0004;
    @(negedge clk);
  endtask

  task automatic adopt();
    for (int i = 0; i < 8; i++) begin lvAng[i] = stAng[i]; lvUp[i] = stUp[i]; end
    lvCnt = stCnt;
  endtask

  task automatic checkGap(bit exp, string tag);
    @(posedge clk); @(posedge clk); #1;
    checks++;
    if (gapFault !== exp) begin
      fails++;
      $display("FAIL %s R8 gapFault act=%0b exp=%0b", tag, gapFault, exp);
    end
  endtask

  // R1
  task automatic testReset();
    #1;
    checks++;
    if (level !== 4'sd0 || upperCnt !== 3'd2 || lowerCnt !== 3'd2 || gapFault !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset act=%0d/%0d/%0d/%0b exp=0/2/2/0", level, upperCnt, lowerCnt, gapFault);
    end
    @(negedge clk) rstN = 1'b1;
    checkPhase(16'h1000, "R1 empty");
    checkPhase(16'h5000, "R1 empty");
    checkPhase(16'hB000, "R1 empty");
  endtask

  // R2 R3 R4 R5
  task automatic testBasic();
    writeEntry(0, 16'h0800, 1);
    writeEntry(1, 16'h1400, 1);
    writeEntry(2, 16'h2000, 0);
    writeEntry(3, 16'h3000, 1);
    writeCount(4);
    checkGap(1'b0, "basic");
    armOnly(); wrapPhase(); adopt();
    sweep("basic");
    checkPhase(16'h0800, "R2 edge");
    checkPhase(16'h07FF, "R2 edge");
    checkPhase(16'h7800, "R3 edge");
    checkPhase(16'h7801, "R3 edge");
    checkPhase(16'h8800, "R4 edge");
    checkPhase(16'hF800, "R4 edge");
  endtask

  // R6
  task automatic testStaging();
    writeEntry(0, 16'h0400, 0);
    writeCount(1);
    checkPhase(16'h1800, "R6 staged");
    armOnly();
    checkPhase(16'h2000, "R6 armed");
    checkPhase(16'h9000, "R6 armed no wrap");
    checkPhase(16'h1800, "R6 armed backward");
    wrapPhase(); adopt();
    checkPhase(16'h1800, "R6 after wrap");
    checkPhase(16'h9800, "R6 after wrap");
  endtask

  // R7
  task automatic testClamp();
    writeEntry(0, 16'h0400, 1);
    writeEntry(1, 16'h0800, 1);
    writeEntry(2, 16'h0C00, 1);
    writeCount(3);
    armOnly(); wrapPhase(); adopt();
    checkPhase(16'h1000, "R7 top");
    checkPhase(16'h9000, "R7 bottom");
    checkPhase(16'h6000, "R7 mirror");
  endtask

  // R9
  task automatic testStale();
    writeEntry(0, 16'h1000, 1);
    writeEntry(1, 16'h1800, 1);
    writeCount(1);
    armOnly(); wrapPhase(); adopt();
    checkPhase(16'h2000, "R9 stale");
    checkPhase(16'hA000, "R9 stale");
  endtask

  // R8
  task automatic testGap();
    writeEntry(0, 16'h1000, 1);
    writeEntry(1, 16'h1010, 1);
    writeCount(2);
    checkGap(1'b1, "R8 close pair");
    writeCount(1);
    checkGap(1'b0, "R8 single");
    writeEntry(0, 16'h0008, 1);
    checkGap(1'b1, "R8 near zero");
    writeEntry(0, 16'h3FF8, 1);
    checkGap(1'b1, "R8 near quarter");
    writeEntry(0, 16'h2000, 1);
    checkGap(1'b0, "R8 clean");
    writeCount(0);
    checkGap(1'b0, "R8 empty");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testBasic();
    testStaging();
    testClamp();
    testStale();
    testGap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule